// File: doc/BRIEF.md
# Dual-Edge Converter Lane Packer

This block sits directly behind the input pins of a fast two-channel converter (I and Q). Each channel delivers four 8-bit sample lanes with a forwarded clock that runs at a quarter of the sample rate. Two lanes of each channel are valid at the rising clock edge and the other two at the falling edge. The block captures both edge groups and merges them into one time-ordered 32-bit word per channel in each clock period. It then collects four such words into a 128-bit beat per channel.

A completed beat is presented with a one-cycle valid strobe. The intended consumer is a clock-crossing FIFO written in the same forwarded clock. The converter cannot be paused. If the sink is not ready when a beat completes, the beat is discarded and a sticky overflow flag is raised. An enable input decides which clock periods contribute words. Periods with enable low leave the packing state untouched.

Top module: `adc_lane_packer`

## Requirements
- R1: While the synchronous reset is high, and on the cycle after it, `out_valid` and `overflow` are 0. Reset also empties any partly filled beat.
- R2: Within each 32-bit word, byte 0 is the sample on rising-edge lane 0 (`*_rise_lanes[7:0]`), byte 1 is rising-edge lane 1 (`[15:8]`), byte 2 is falling-edge lane 0 (`*_fall_lanes[7:0]`) and byte 3 is falling-edge lane 1 (`[15:8]`). The rising pair is sampled at a rising edge and the falling pair at the falling edge that follows it. Byte n is the n-th sample of that period in time.
- R3: Four accepted words make one beat. The earliest word occupies bits [31:0] and the latest occupies bits [127:96].
- R4: `out_valid` is high for exactly one cycle per completed beat, and never on two consecutive cycles. The beat data holds its value between strobes.
- R5: A clock period whose rising edge sees `en` low contributes no word, and the partial beat stays as it was.
- R6: If `out_ready` is low at the edge where the fourth word is taken in, no strobe is produced for that beat. `overflow` becomes 1 and stays 1 until reset.
- R7: The Q channel follows the same capture, ordering and packing as I, with the same timing and the same strobe, and independent data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Forwarded converter clock; both edges used |
| rst | input | 1 | Synchronous reset, active high (rising edge) |
| en | input | 1 | Accept the word of this period |
| i_rise_lanes | input | 16 | I lanes valid at the rising edge |
| i_fall_lanes | input | 16 | I lanes valid at the falling edge |
| q_rise_lanes | input | 16 | Q lanes valid at the rising edge |
| q_fall_lanes | input | 16 | Q lanes valid at the falling edge |
| out_ready | input | 1 | Sink can take a beat |
| out_valid | output | 1 | One-cycle strobe for a completed beat |
| i_beat | output | 128 | Packed I beat |
| q_beat | output | 128 | Packed Q beat |
| overflow | output | 1 | Sticky: a beat was dropped |

## Verification
The hardest state to reach is a beat that completes while the sink is not ready. Reaching it needs the word count to line up with a low `out_ready` two edges after the last word is taken in. The stimulus changes `out_ready` only while the pipeline is idle. It then feeds whole groups of words, so the drop lands on a known beat. Sending more beats afterwards shows that the flag stays set. A reset issued with half a beat collected shows that the leftover words never reach the output.

// File: rtl/adc_lane_packer.sv
module adc_lane_packer #(
  parameter int SAMPLE_W = 8,
  parameter int LANES    = 4,
  parameter int BEATS    = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              en,
  input  logic [SAMPLE_W*LANES/2-1:0]       i_rise_lanes,
  input  logic [SAMPLE_W*LANES/2-1:0]       i_fall_lanes,
  input  logic [SAMPLE_W*LANES/2-1:0]       q_rise_lanes,
  input  logic [SAMPLE_W*LANES/2-1:0]       q_fall_lanes,
  input  logic                              out_ready,
  output logic                              out_valid,
  output logic [SAMPLE_W*LANES*BEATS-1:0]   i_beat,
  output logic [SAMPLE_W*LANES*BEATS-1:0]   q_beat,
  output logic                              overflow
);
  localparam int HALF_W = SAMPLE_W * LANES / 2;
  localparam int WORD_W = 2 * HALF_W;
  localparam int BUS_W  = WORD_W * BEATS;
  localparam int CNT_W  = (BEATS > 2) ? $clog2(BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BEATS - 1);

  logic [1:0][HALF_W-1:0] rise_in, fall_in, rise_q, fall_q;
  logic [1:0][WORD_W-1:0] word_q;
  logic [1:0][BUS_W-1:0]  acc_q, beat_q;
  logic                   rise_vld, word_vld;
  logic [CNT_W-1:0]       cnt;

  assign rise_in = {q_rise_lanes, i_rise_lanes};
  assign fall_in = {q_fall_lanes, i_fall_lanes};
  assign i_beat  = beat_q[0];
  assign q_beat  = beat_q[1];

  always_ff @(negedge clk)
    fall_q <= fall_in;

  always_ff @(posedge clk) begin
    rise_q <= rise_in;
    for (int ch = 0; ch < 2; ch++)
      word_q[ch] <= {fall_q[ch], rise_q[ch]};

    if (rst) begin
      rise_vld  <= 1'b0;
      word_vld  <= 1'b0;
      cnt       <= '0;
      out_valid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      rise_vld  <= en;
      word_vld  <= rise_vld;
      out_valid <= 1'b0;
      if (word_vld) begin
        cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
        for (int ch = 0; ch < 2; ch++)
          acc_q[ch][cnt*WORD_W +: WORD_W] <= word_q[ch];
        if (cnt == LAST) begin
          if (out_ready) begin
            out_valid <= 1'b1;
            for (int ch = 0; ch < 2; ch++)
              beat_q[ch] <= {word_q[ch], acc_q[ch][BUS_W-WORD_W-1:0]};
          end else begin
            overflow <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/adc_lane_packer_chk.sv
module adc_lane_packer_chk (
  input logic clk,
  input logic rst,
  input logic out_ready,
  input logic out_valid,
  input logic overflow
);
  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (!out_valid && !overflow));

  a_r4_single_pulse: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  a_r6_sticky_flag: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r6_drop_no_strobe: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> !out_valid);

  a_r6_strobe_needs_ready: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(out_ready));
endmodule

bind adc_lane_packer adc_lane_packer_chk u_chk (
  .clk(clk), .rst(rst), .out_ready(out_ready),
  .out_valid(out_valid), .overflow(overflow)
);

// File: tb/adc_lane_packer_tb.sv
module adc_lane_packer_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic out_ready = 1'b1;
  logic [15:0] i_rise_lanes = '0, i_fall_lanes = '0, q_rise_lanes = '0, q_fall_lanes = '0;
  logic out_valid, overflow;
  logic [127:0] i_beat, q_beat;

  int checks = 0, fails = 0;
  logic [255:0] expq[$];
  logic [127:0] part_i, part_q;
  int part_n = 0;
  logic exp_ovf = 1'b0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_lane_packer u_dut (
    .clk(clk), .rst(rst), .en(en),
    .i_rise_lanes(i_rise_lanes), .i_fall_lanes(i_fall_lanes),
    .q_rise_lanes(q_rise_lanes), .q_fall_lanes(q_fall_lanes),
    .out_ready(out_ready), .out_valid(out_valid),
    .i_beat(i_beat), .q_beat(q_beat), .overflow(overflow)
  );

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // R2 R3 R5 R6 R7: driver and reference model
  task automatic send(input logic e, input logic [31:0] wi, input logic [31:0] wq);
    @(negedge clk); #1;
    en = e; i_rise_lanes = wi[15:0]; q_rise_lanes = wq[15:0];
    @(posedge clk); #1;
    i_fall_lanes = wi[31:16]; q_fall_lanes = wq[31:16];
    if (e) begin
      part_i[part_n*32 +: 32] = wi;
      part_q[part_n*32 +: 32] = wq;
      part_n++;
      if (part_n == 4) begin
        part_n = 0;
        if (out_ready) expq.push_back({part_q, part_i});
        else exp_ovf = 1'b1;
      end
    end
  endtask

  task automatic burst(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      logic [31:0] wi = {8'(seed+4*k+3), 8'(seed+4*k+2), 8'(seed+4*k+1), 8'(seed+4*k)};
      send(1'b1, wi, wi ^ 32'hA5C3_1E77 ^ {k[7:0], 24'h0});
    end
  endtask

  task automatic drain();
    for (int k = 0; k < 4; k++) send(1'b0, 32'hDEAD_BEEF, 32'h0BAD_F00D);
  endtask

  task automatic do_reset();
    @(negedge clk); #1; rst = 1'b1; en = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    check("R1 valid in reset", {255'b0, out_valid}, 256'd0);
    check("R1 overflow in reset", {255'b0, overflow}, 256'd0);
    @(negedge clk); #1; rst = 1'b0;
    part_n = 0; exp_ovf = 1'b0;
  endtask

  // scoreboard monitor: R3 R4 R7
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (expq.size() == 0) begin
        checks++; fails++;
        $display("FAIL R4 unexpected strobe actual=%h expected=none", {q_beat, i_beat});
      end else begin
        check("R3/R7 beat", {q_beat, i_beat}, expq.pop_front());
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    do_reset();
    // R2 R3 R4 R7: plain streaming
    burst(8, 8'h10);
    drain();
    check("R4 all beats seen", 256'(expq.size()), 256'd0);
    // R5: enable gaps keep partial beat intact
    for (int k = 0; k < 11; k++)
      send((k % 3) != 1, {8'(k*7+3), 8'(k*7+2), 8'(k*7+1), 8'(k*7)}, {8'(k), 8'(~k), 8'(k*3), 8'hC0});
    burst(2, 8'h60);
    drain();
    check("R5 gapped beats seen", 256'(expq.size()), 256'd0);
    check("R6 no overflow yet", {255'b0, overflow}, {255'b0, exp_ovf});
    // R6: drop with ready low
    @(negedge clk); #1; out_ready = 1'b0;
    burst(4 + (4 - part_n) % 4, 8'h80);
    drain();
    check("R6 overflow set", {255'b0, overflow}, 256'd1);
    @(negedge clk); #1; out_ready = 1'b1;
    burst(8, 8'hA0);
    drain();
    check("R6 overflow sticky", {255'b0, overflow}, 256'd1);
    check("R6 beats after drop", 256'(expq.size()), 256'd0);
    // R1: reset discards partial beat
    burst(2, 8'hC0);
    drain();
    do_reset();
    check("R1 overflow cleared", {255'b0, overflow}, 256'd0);
    burst(4, 8'hE0);
    drain();
    check("R1 fresh beat only", 256'(expq.size()), 256'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule